// File: doc/BRIEF.md
# Nine-bit multidrop address filter

This block sits behind a UART receiver on a node of a shared serial bus where one master talks to many listeners. Every received word carries eight data bits plus a ninth bit in the position normally used for parity. A ninth bit of 1 marks the word as an address. A ninth bit of 0 marks it as ordinary data. The filter compares each address word with the node's own address and remembers whether the node is currently selected. It passes data bytes on to the host only while the node is selected.

An address word can also raise an interrupt toward the host, gated by a mask-enable input. This lets host software follow the addressing traffic without reading every byte. The interrupt is driven only by the word being evaluated, one at a time, as it arrives on the receive strobe. Once raised, it is held until the host acknowledges it. All outputs are registered, with one cycle of latency from the receive strobe.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, `sel_o`, `irq_o` and `out_valid_o` are 0 and `out_data_o` is 8'h00.
- R2: A strobed word with `rx_ninth_i`=1 whose byte equals `node_addr_i` sets `sel_o` to 1 in the following cycle.
- R3: A strobed word with `rx_ninth_i`=1 whose byte differs from `node_addr_i` clears `sel_o` in the following cycle.
- R4: A strobed word with `rx_ninth_i`=0 that arrives while `sel_o` is 1 produces a one-cycle `out_valid_o` pulse in the following cycle, with that byte on `out_data_o`. `out_data_o` keeps the last forwarded byte until the next one is forwarded.
- R5: A strobed word with `rx_ninth_i`=0 that arrives while `sel_o` is 0 produces no `out_valid_o` pulse and leaves `out_data_o`, `sel_o` and `irq_o` unchanged.
- R6: Address words (`rx_ninth_i`=1) are never forwarded, so `out_valid_o` is 0 in the cycle after one.
- R7: With `irq_en_i`=1, an address word sets `irq_o` in the following cycle whether it matches or not. `irq_o` then stays 1 until it is acknowledged.
- R8: With `irq_en_i`=0, an address word leaves `irq_o` unchanged but still updates `sel_o`. Data words never raise `irq_o`.
- R9: `irq_ack_i`=1 clears `irq_o` in the following cycle, unless an interrupting address word is strobed in the same cycle, in which case `irq_o` stays 1.
- R10: `node_addr_i` is compared only in the cycle the address word is strobed. Changing it afterwards does not change `sel_o`.
- R11: While `rx_valid_i` is 0, `sel_o` and `out_data_o` hold and `out_valid_o` is 0, whatever `rx_data_i` and `rx_ninth_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | Received word strobe from the UART receiver |
| rx_data_i | input | 8 | Received data byte |
| rx_ninth_i | input | 1 | Ninth bit: 1 = address word, 0 = data word |
| node_addr_i | input | 8 | This node's assigned address |
| irq_en_i | input | 1 | Enables the interrupt on address words |
| irq_ack_i | input | 1 | Host acknowledge, clears the pending interrupt |
| out_valid_o | output | 1 | One-cycle strobe for a forwarded data byte |
| out_data_o | output | 8 | Last forwarded data byte |
| sel_o | output | 1 | Node is currently selected |
| irq_o | output | 1 | Address-word interrupt pending |

## Verification
The bench goes after the points where selection changes:
- A data word right after a matching address must be forwarded. A design that samples the old selection one cycle late would drop it.
- A data word right after a mismatching address must be dropped. A design that only ever sets the selection would keep leaking bytes meant for another node.
- An acknowledge that coincides with a new interrupting address word must leave the interrupt set. A design that gives the acknowledge priority would lose that event.

It also changes the node address in the cycle after a match, to catch comparison against a stale or late address. It masks the interrupt while addresses keep arriving, to show that selection still follows the bus. Finally, it drives address-looking bits with the strobe low, to catch decoding that ignores the strobe.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DATA = 2'd1,
        FR_ADDR = 2'd2
    } frame_kind_e;

endpackage

// File: rtl/mdrop_frame_decode.sv
module mdrop_frame_decode
    import mdrop_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              valid_i,
    input  logic              ninth_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [DATA_W-1:0] own_addr_i,
    output frame_kind_e       kind_o,
    output logic              hit_o
);

    logic [DATA_W-1:0] bit_eq;

    // Per-bit equality, reduced below
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit_eq
        assign bit_eq[i] = ~(byte_i[i] ^ own_addr_i[i]);
    end

    always_comb begin
        if (!valid_i) begin
            kind_o = FR_IDLE;
        end else if (ninth_i) begin
            kind_o = FR_ADDR;
        end else begin
            kind_o = FR_DATA;
        end
        hit_o = &bit_eq;
    end

endmodule

// File: rtl/mdrop_irq_ctrl.sv
module mdrop_irq_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raise_i,
    input  logic ack_i,
    output logic pend_o
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (ack_i) begin
            pend_d = 1'b0;
        end
        if (raise_i) begin
            pend_d = 1'b1; // a new event outranks a concurrent acknowledge
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !ack_i) |=> pend_o);

    assert_irq_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pend_o && !raise_i) |=> !pend_o);

    assert_irq_raise_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raise_i && ack_i) |=> pend_o);

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdrop_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_ninth_i,
    input  logic [DATA_W-1:0] node_addr_i,
    input  logic              irq_en_i,
    input  logic              irq_ack_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              sel_o,
    output logic              irq_o
);

    typedef struct packed {
        logic              sel;
        logic              fwd_vld;
        logic [DATA_W-1:0] fwd_data;
    } filt_state_t;

    frame_kind_e kind;
    logic        hit;
    logic        irq_raise;
    filt_state_t st_d, st_q;

    mdrop_frame_decode #(
        .DATA_W(DATA_W)
    ) u_decode (
        .valid_i   (rx_valid_i),
        .ninth_i   (rx_ninth_i),
        .byte_i    (rx_data_i),
        .own_addr_i(node_addr_i),
        .kind_o    (kind),
        .hit_o     (hit)
    );

    assign irq_raise = (kind == FR_ADDR) && irq_en_i;

    mdrop_irq_ctrl u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raise_i(irq_raise),
        .ack_i  (irq_ack_i),
        .pend_o (irq_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.fwd_vld = 1'b0;
        unique case (kind)
            FR_ADDR: begin
                st_d.sel = hit;
            end
            FR_DATA: begin
                if (st_q.sel) begin
                    st_d.fwd_vld  = 1'b1;
                    st_d.fwd_data = rx_data_i;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o       = st_q.sel;
    assign out_valid_o = st_q.fwd_vld;
    assign out_data_o  = st_q.fwd_data;

    assert_match_selects_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && rx_ninth_i && (rx_data_i == node_addr_i)) |=> sel_o);

    assert_miss_deselects_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && rx_ninth_i && (rx_data_i != node_addr_i)) |=> !sel_o);

    assert_unsel_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && !rx_ninth_i && !sel_o) |=> (!out_valid_o && $stable(out_data_o)));

    assert_addr_not_fwd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && rx_ninth_i) |=> !out_valid_o);

    assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_valid_i |=> (!out_valid_o && $stable(sel_o) && $stable(out_data_o)));

endmodule

// File: tb/mdrop_addr_filter_bench.sv
module mdrop_addr_filter_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_ninth;
    logic [7:0] node_addr;
    logic       irq_en;
    logic       irq_ack;
    logic       out_valid;
    logic [7:0] out_data;
    logic       sel;
    logic       irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference model state
    bit       m_sel, m_irq, m_ov;
    bit [7:0] m_od;

    always #2 clk = ~clk;

    mdrop_addr_filter u_mdrop_addr_filter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_data),
        .rx_ninth_i (rx_ninth),
        .node_addr_i(node_addr),
        .irq_en_i   (irq_en),
        .irq_ack_i  (irq_ack),
        .out_valid_o(out_valid),
        .out_data_o (out_data),
        .sel_o      (sel),
        .irq_o      (irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(out_valid == m_ov, tag, "out_valid", out_valid, m_ov);
        check(out_data == m_od, tag, "out_data", out_data, m_od);
        check(sel == m_sel, tag, "sel", sel, m_sel);
        check(irq == m_irq, tag, "irq", irq, m_irq);
    endtask

    // one clock: drive at negedge, update model at posedge, compare 1 ns later
    task automatic cyc(input bit v, input bit [7:0] d, input bit n,
                       input bit en, input bit ack, input string tag);
        bit v_s, n_s, en_s, ack_s;
        bit [7:0] d_s, a_s;
        @(negedge clk);
        rx_valid = v; rx_data = d; rx_ninth = n; irq_en = en; irq_ack = ack;
        v_s = v; d_s = d; n_s = n; en_s = en; ack_s = ack; a_s = node_addr;
        @(posedge clk);
        m_ov = v_s && !n_s && m_sel;
        if (m_ov) m_od = d_s;
        if (v_s && n_s && en_s) m_irq = 1'b1;
        else if (ack_s) m_irq = 1'b0;
        if (v_s && n_s) m_sel = (d_s == a_s);
        #1;
        compare(tag);
    endtask

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_ninth = 1'b0;
        node_addr = 8'h5A; irq_en = 1'b1; irq_ack = 1'b0;
        m_sel = 0; m_irq = 0; m_ov = 0; m_od = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 compare("R1");

        cyc(1, 8'h11, 0, 1, 0, "R5");            // data while unselected
        cyc(1, 8'h33, 1, 1, 0, "R7");            // mismatching address, irq
        cyc(0, 8'h00, 0, 1, 0, "R7");
        cyc(0, 8'h00, 0, 1, 0, "R7");            // held
        cyc(0, 8'h00, 0, 1, 1, "R9");            // ack clears
        cyc(1, 8'h5A, 1, 1, 0, "R2");            // match selects, not forwarded
        cyc(1, 8'hA1, 0, 1, 0, "R4");            // forwarded next cycle
        cyc(1, 8'hB2, 0, 1, 0, "R4");            // back-to-back
        cyc(0, 8'h5A, 1, 1, 0, "R11");           // no strobe
        cyc(0, 8'h77, 0, 1, 0, "R11");
        cyc(1, 8'h5A, 1, 1, 1, "R9");            // ack with new event: stays
        cyc(1, 8'hC3, 0, 1, 1, "R9");            // plain ack clears, data fwd
        cyc(1, 8'h77, 1, 0, 0, "R3");            // masked mismatch deselects
        cyc(1, 8'hCC, 0, 0, 0, "R5");            // dropped
        cyc(1, 8'h5A, 1, 0, 0, "R8");            // masked match selects, no irq
        cyc(1, 8'h5A, 1, 1, 0, "R6");            // address never forwarded
        // R10: node address changes after the match
        node_addr = 8'h42;
        cyc(1, 8'h42, 1, 1, 1, "R10");
        node_addr = 8'h99;
        cyc(1, 8'h10, 0, 1, 1, "R10");
        cyc(0, 8'h00, 0, 1, 0, "R10");
        cyc(1, 8'h42, 1, 1, 0, "R10");           // old address no longer matches
        cyc(1, 8'h20, 0, 1, 1, "R5");

        node_addr = 8'h3C;
        for (int i = 0; i < 400; i++) begin
            bit [7:0] d;
            bit n;
            d = ($urandom % 4 == 0) ? 8'h3C : 8'($urandom);
            n = ($urandom % 3 == 0);
            cyc(($urandom % 4) != 0, d, n, ($urandom % 4) != 0,
                ($urandom % 3) == 0, "R2/R3/R4/R5/R7/R9");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule